// File: doc/BRIEF.md
# Shared-Bus Address Splitter

This block sits between a processor that time-shares one byte-wide bus for address and data, and a memory system that needs a full 14-bit address held steady. A cycle-state code from the processor says what the bus carries. In the low-address state the bus holds address bits 7..0. In the high-address state it holds address bits 13..8 in its six lower lines and two cycle-type bits in its top lines. In the data state the bus carries data. On each rising clock edge of a low or high state the block captures the bus into the matching latch. It then holds the assembled address until the next low-address capture.

An ordering state machine enforces the capture sequence. Its three states are EMPTY (after reset, no address), LOW_HELD (low byte taken) and READY (full address held). Its transitions are as follows. From any state, a low-address code goes to LOW_HELD. From LOW_HELD, a high-address code goes to READY. Every other code keeps the current state. A high-address code that does not follow a low-address code is ignored.

In the data state, and only while the machine is READY, two strobes steer the data. The read strobe turns the bus around and drives memory read data to the processor. The write strobe passes bus data to the memory write port. Cycle-state codes are 0 = idle, 1 = low address, 2 = high address, 3 = data.

Top module: `addr_split_top`

## Requirements
- R1: While reset is active, mem_addr is 0, cyc_type is 0, bus_oe is 0 and mem_wr_en is 0.
- R2: On a rising edge with phase_code = 1, bus_in[7:0] is stored into mem_addr[7:0], whatever the current state.
- R3: On a rising edge with phase_code = 2 directly in state LOW_HELD, bus_in[5:0] is stored into mem_addr[13:8] and bus_in[7:6] into cyc_type, and the state becomes READY.
- R4: A phase_code = 2 edge in state EMPTY or READY changes neither mem_addr nor cyc_type.
- R5: mem_addr and cyc_type hold their values through idle (0) and data (3) states until the next low-address capture.
- R6: In state READY with phase_code = 3 and rd_stb = 1, bus_oe is 1 and bus_out equals mem_rd_data in the same cycle.
- R7: In state READY with phase_code = 3, wr_stb = 1 and rd_stb = 0, mem_wr_en is 1 and mem_wr_data equals bus_in in the same cycle.
- R8: When rd_stb and wr_stb are both 1 in a valid data state, the read wins: bus_oe is 1 and mem_wr_en is 0.
- R9: Strobes are ignored outside phase_code = 3, and also in states EMPTY or LOW_HELD: bus_oe and mem_wr_en stay 0.
- R10: A low-address capture after READY replaces only mem_addr[7:0], keeps mem_addr[13:8], and blocks data strobes until a new high-address capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| phase_code | input | 2 | Cycle state: 0 idle, 1 low addr, 2 high addr, 3 data |
| bus_in | input | 8 | Shared bus as seen from the processor |
| bus_out | output | 8 | Read data driven toward the processor |
| bus_oe | output | 1 | Drive enable for bus_out |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| mem_addr | output | 14 | Latched memory address |
| cyc_type | output | 2 | Latched cycle-type bits |
| mem_rd_data | input | 8 | Data from memory |
| mem_wr_data | output | 8 | Data to memory |
| mem_wr_en | output | 1 | Memory write enable |

## Verification
A read strobe and a write strobe can be asserted in the same data cycle. The bench provokes this on a READY address and judges that the bus is driven with memory data while the write enable stays low. A second collision is a new low-address capture landing on an address that is already complete. The bench issues such a capture with a read strobe in the next data state. It then checks that the lower byte changed, the upper bits were kept, and the read was refused.

// File: rtl/addr_split_pkg.sv
package addr_split_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2,
        PH_DATA = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        ST_EMPTY    = 2'd0,
        ST_LOW_HELD = 2'd1,
        ST_READY    = 2'd2
    } seq_state_e;

endpackage

// File: rtl/addr_seq_fsm.sv
module addr_seq_fsm
    import addr_split_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e phase,
    output logic   cap_low,
    output logic   cap_high,
    output logic   data_ok
);

    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (phase == PH_LOW) state_d = ST_LOW_HELD;
            end
            ST_LOW_HELD: begin
                if (phase == PH_HIGH) state_d = ST_READY;
                else if (phase == PH_LOW) state_d = ST_LOW_HELD;
            end
            ST_READY: begin
                if (phase == PH_LOW) state_d = ST_LOW_HELD;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        cap_low  = 1'b0;
        cap_high = 1'b0;
        data_ok  = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                cap_low = (phase == PH_LOW);
            end
            ST_LOW_HELD: begin
                cap_low  = (phase == PH_LOW);
                cap_high = (phase == PH_HIGH);
            end
            ST_READY: begin
                cap_low = (phase == PH_LOW);
                data_ok = (phase == PH_DATA);
            end
            default: ;
        endcase
    end

    // R5
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && phase != PH_LOW) |=> state_q == ST_READY);

    // R3
    ready_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_READY) |-> $past(phase) == PH_HIGH);

endmodule

// File: rtl/addr_latch.sv
module addr_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

endmodule

// File: rtl/data_steer.sv
module data_steer #(
    parameter int BUS_W = 8
) (
    input  logic             data_ok,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic [BUS_W-1:0] bus_in,
    input  logic [BUS_W-1:0] mem_rd_data,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe,
    output logic [BUS_W-1:0] mem_wr_data,
    output logic             mem_wr_en
);

    always_comb begin
        bus_oe      = data_ok && rd_stb;
        mem_wr_en   = data_ok && wr_stb && !rd_stb;
        bus_out     = bus_oe ? mem_rd_data : '0;
        mem_wr_data = bus_in;
    end

    // R8
    always_comb begin
        turn_excl_chk: assert (!(bus_oe && mem_wr_en));
    end

endmodule

// File: rtl/addr_split_top.sv
module addr_split_top
    import addr_split_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int ADDR_W = 14
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  phase_code,
    input  logic [BUS_W-1:0]            bus_in,
    output logic [BUS_W-1:0]            bus_out,
    output logic                        bus_oe,
    input  logic                        rd_stb,
    input  logic                        wr_stb,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [2*BUS_W-ADDR_W-1:0]   cyc_type,
    input  logic [BUS_W-1:0]            mem_rd_data,
    output logic [BUS_W-1:0]            mem_wr_data,
    output logic                        mem_wr_en
);

    localparam int HI_W   = ADDR_W - BUS_W;
    localparam int TYPE_W = BUS_W - HI_W;

    phase_e phase;
    logic   cap_low, cap_high, data_ok;
    logic [BUS_W-1:0] low_q, high_q;

    assign phase = phase_e'(phase_code);

    addr_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .cap_low  (cap_low),
        .cap_high (cap_high),
        .data_ok  (data_ok)
    );

    addr_latch #(.W(BUS_W)) u_low (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cap_low),
        .d     (bus_in),
        .q     (low_q)
    );

    addr_latch #(.W(BUS_W)) u_high (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cap_high),
        .d     (bus_in),
        .q     (high_q)
    );

    assign mem_addr = {high_q[HI_W-1:0], low_q};
    assign cyc_type = high_q[BUS_W-1 -: TYPE_W];

    data_steer #(.BUS_W(BUS_W)) u_steer (
        .data_ok     (data_ok),
        .rd_stb      (rd_stb),
        .wr_stb      (wr_stb),
        .bus_in      (bus_in),
        .mem_rd_data (mem_rd_data),
        .bus_out     (bus_out),
        .bus_oe      (bus_oe),
        .mem_wr_data (mem_wr_data),
        .mem_wr_en   (mem_wr_en)
    );

    // R9
    oe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (phase_code == 2'd3 && rd_stb));

    // R9
    wr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (phase_code == 2'd3 && wr_stb));

    // R5
    addr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_code == 2'd0 || phase_code == 2'd3) |=> $stable(mem_addr));

endmodule

// File: tb/sim_addr_split_top.sv
module sim_addr_split_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  phase_code = 2'd0;
    logic [7:0]  bus_in = 8'h00;
    logic [7:0]  bus_out;
    logic        bus_oe;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [13:0] mem_addr;
    logic [1:0]  cyc_type;
    logic [7:0]  mem_rd_data = 8'h00;
    logic [7:0]  mem_wr_data;
    logic        mem_wr_en;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    addr_split_top u0 (
        .clk(clk), .rst_n(rst_n), .phase_code(phase_code), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .mem_addr(mem_addr), .cyc_type(cyc_type), .mem_rd_data(mem_rd_data),
        .mem_wr_data(mem_wr_data), .mem_wr_en(mem_wr_en)
    );

    // lo, hi byte, rd, wr, read data, write data
    localparam int NV = 6;
    localparam logic [33:0] VEC [NV] = '{
        {8'h34, 8'h12, 1'b1, 1'b0, 8'hA5, 8'h00},
        {8'hFF, 8'hFF, 1'b0, 1'b1, 8'h00, 8'h5A},
        {8'h00, 8'h40, 1'b1, 1'b1, 8'h3C, 8'hC3},
        {8'h81, 8'hBF, 1'b0, 1'b1, 8'h11, 8'hEE},
        {8'h7E, 8'h80, 1'b1, 1'b0, 8'h99, 8'h00},
        {8'h01, 8'h3F, 1'b0, 1'b0, 8'h77, 8'h66}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic [1:0] ph, input logic [7:0] b, input logic r, input logic w);
        @(negedge clk);
        phase_code = ph; bus_in = b; rd_stb = r; wr_stb = w;
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=<50000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [13:0] exp_addr;
        logic [1:0]  exp_type;

        // R1: reset state, with bus activity applied during reset
        cyc(2'd1, 8'hFF, 1'b1, 1'b1);
        cyc(2'd3, 8'hFF, 1'b1, 1'b1);
        chk("R1 addr", mem_addr, 14'h0);
        chk("R1 type", cyc_type, 2'd0);
        chk("R1 oe", bus_oe, 1'b0);
        chk("R1 wr_en", mem_wr_en, 1'b0);
        cyc(2'd0, 8'h00, 1'b0, 1'b0);
        rst_n = 1'b1;

        // R4: high phase with no low phase pending is ignored
        cyc(2'd2, 8'hFF, 1'b0, 1'b0);
        cyc(2'd3, 8'h00, 1'b1, 1'b0);
        chk("R4 addr from empty", mem_addr, 14'h0);
        chk("R4 type from empty", cyc_type, 2'd0);
        chk("R9 oe while empty", bus_oe, 1'b0);

        // table walk: R2 R3 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            logic [7:0] lo, hi, rdat, wdat;
            logic r, w;
            {lo, hi, r, w, rdat, wdat} = VEC[i];
            mem_rd_data = rdat;
            cyc(2'd1, lo, 1'b0, 1'b0);
            cyc(2'd2, hi, r, w);
            chk("R2 low byte", mem_addr[7:0], lo);
            chk("R9 oe in high phase", bus_oe, 1'b0);
            chk("R9 wr_en in high phase", mem_wr_en, 1'b0);
            cyc(2'd3, wdat, r, w);
            chk("R3 high bits", mem_addr[13:8], {2'b00, hi[5:0]});
            chk("R3 type", cyc_type, hi[7:6]);
            chk("R6 oe", bus_oe, r);
            if (r) chk("R6 bus_out", bus_out, rdat);
            chk("R7/R8 wr_en", mem_wr_en, w && !r);
            if (w && !r) chk("R7 wr_data", mem_wr_data, wdat);
            cyc(2'd0, 8'hC9, 1'b1, 1'b1);
            chk("R9 oe idle", bus_oe, 1'b0);
            chk("R9 wr_en idle", mem_wr_en, 1'b0);
            cyc(2'd3, 8'h00, 1'b0, 1'b0);
            chk("R5 addr held", mem_addr, {hi[5:0], lo});
            chk("R5 type held", cyc_type, hi[7:6]);
        end

        // R8: both strobes together on a ready address
        cyc(2'd1, 8'h55, 1'b0, 1'b0);
        cyc(2'd2, 8'h6A, 1'b0, 1'b0);
        mem_rd_data = 8'hD2;
        cyc(2'd3, 8'h2D, 1'b1, 1'b1);
        chk("R8 oe", bus_oe, 1'b1);
        chk("R8 wr_en", mem_wr_en, 1'b0);
        chk("R8 bus_out", bus_out, 8'hD2);
        exp_addr = {6'h2A, 8'h55};
        exp_type = 2'b01;

        // R4: a second high phase after ready is ignored
        cyc(2'd2, 8'hC0, 1'b0, 1'b0);
        cyc(2'd0, 8'h00, 1'b0, 1'b0);
        chk("R4 addr from ready", mem_addr, exp_addr);
        chk("R4 type from ready", cyc_type, exp_type);

        // R10: new low capture on a complete address
        cyc(2'd1, 8'hE7, 1'b0, 1'b0);
        cyc(2'd3, 8'h00, 1'b1, 1'b0);
        chk("R10 low replaced", mem_addr, {exp_addr[13:8], 8'hE7});
        chk("R10 type kept", cyc_type, exp_type);
        chk("R10 read refused", bus_oe, 1'b0);
        cyc(2'd3, 8'h44, 1'b0, 1'b1);
        chk("R10 write refused", mem_wr_en, 1'b0);

        // R10: a new high capture releases data access
        cyc(2'd2, 8'h03, 1'b0, 1'b0);
        cyc(2'd3, 8'h44, 1'b0, 1'b1);
        chk("R10 new addr", mem_addr, {6'h03, 8'hE7});
        chk("R7 write after recapture", mem_wr_en, 1'b1);
        chk("R7 wr_data after recapture", mem_wr_data, 8'h44);

        // R1: reset in the middle of a ready address
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        chk("R1 async addr", mem_addr, 14'h0);
        chk("R1 async oe", bus_oe, 1'b0);
        chk("R1 async wr_en", mem_wr_en, 1'b0);

        finish_run();
    end

endmodule